// File: doc/BRIEF.md
# Serial-Flash Sector Write-Protect Command Unit

This unit sits inside a serial-flash slave and handles the instruction that marks one 64 KB sector as write-protected. It watches the chip-select, serial clock and serial data-in lines of an SPI mode 0 link. It uses the fast internal clock to sample them. It assembles bytes and decides whether the opcode is the protect instruction. It extracts the sector index from the 24-bit address that follows. The outcome is resolved only when chip-select returns high.

The unit holds one protect flag per sector and the write-enable latch. It publishes both to the rest of the device, together with a registered copy of the protection-lock status bit. The write-enable latch is set by a pulse from the write-enable decoder. A sibling unprotect handler clears protect flags through a mask input. The unit never drives the data-out pin.

Top module: `sect_guard`

## Requirements
- R1: After synchronous reset, every bit of `prot_vec` is 1 and `wel` is 0.
- R2: A one-cycle `wel_set` pulse makes `wel` read 1 on the following clock, when no frame ends in that cycle.
- R3: A frame must carry opcode 8'h36 followed by three address bytes, all sent MSB first. WEL must be 1, `lock_in` must be 0, and CS must rise after a multiple of 8 bits. Such a frame sets `prot_vec[A19:A16]` to 1 and clears `wel`. Address bits A23–A20 and A15–A0 do not influence which sector is chosen.
- R4: Whole bytes sent after the third address byte are ignored, and the frame still commits as in R3.
- R5: If CS rises after the opcode but before the third address byte is complete, `prot_vec` is unchanged and `wel` is cleared.
- R6: If CS rises on a bit count that is not a multiple of 8, `prot_vec` is unchanged and `wel` is cleared. This holds even when all three address bytes were received.
- R7: While `lock_in` is 1, a protect frame leaves `prot_vec` unchanged and clears `wel`. The `locked` output shows `lock_in` one clock later.
- R8: A well-formed protect frame that ends while `wel` is 0 leaves `prot_vec` unchanged and `wel` at 0.
- R9: A frame whose first byte is not 8'h36, or that ends before a full first byte, changes neither `prot_vec` nor `wel`.
- R10: `so_oe` and `so` are always 0, so the data-out pad stays high-impedance.
- R11: A one-cycle `unprot_mask` pulse clears each `prot_vec` bit whose mask bit is 1, on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip-select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | SPI serial data in, sampled on SCK rise |
| so | output | 1 | SPI data out value (always 0) |
| so_oe | output | 1 | Output enable for the SO pad (always 0) |
| wel_set | input | 1 | Pulse from the write-enable decoder |
| lock_in | input | 1 | Protection-lock status bit |
| unprot_mask | input | NSECT | Pulse mask from the unprotect handler |
| prot_vec | output | NSECT | Protect flag per sector, 1 = protected |
| wel | output | 1 | Write-enable latch |
| locked | output | 1 | Registered copy of lock_in |

## Verification
A wrong bit or byte count inside the shifter first shows at the port when chip-select rises. The frame is then wrongly committed or aborted, and `prot_vec` or `wel` holds the wrong value about five internal clocks later. A miscaptured sector index shows in that same update as a different bit of `prot_vec` set to 1. A stale opcode match left over from an earlier frame shows as a spurious WEL clear at the end of a short frame. The bench therefore ends each frame with CS high, waits for the update to settle, and compares the whole protection vector, WEL and the lock copy against a model held in the bench.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;

    localparam int unsigned ADDR_BITS   = 24;
    localparam int unsigned ADDR_BYTES  = ADDR_BITS / 8;
    localparam logic [7:0]  OP_PROTECT  = 8'h36;

    // Summary of a frame, produced once at the chip-select rising edge
    typedef struct packed {
        logic valid;    // one-cycle pulse at frame end
        logic is_prot;  // a complete first byte equal to OP_PROTECT
        logic full;     // all address bytes were received
        logic aligned;  // frame ended on a byte boundary
    } frame_t;

    typedef enum logic [2:0] {
        OUT_NONE,    // not a protect frame: nothing happens
        OUT_COMMIT,  // set the addressed protect flag, clear WEL
        OUT_ABORT,   // malformed frame: flags unchanged, clear WEL
        OUT_LOCKED,  // lock bit set: flags unchanged, clear WEL
        OUT_NOWEL    // WEL was low: flags unchanged
    } outcome_t;

    function automatic outcome_t classify(frame_t f, logic wel_now, logic lock_now);
        outcome_t r;
        if (!f.valid || !f.is_prot)        r = OUT_NONE;
        else if (lock_now)                 r = OUT_LOCKED;
        else if (!f.full || !f.aligned)    r = OUT_ABORT;
        else if (!wel_now)                 r = OUT_NOWEL;
        else                               r = OUT_COMMIT;
        return r;
    endfunction

endpackage

// File: rtl/sect_guard_sync.sv
module sect_guard_sync #(
    parameter int unsigned     W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  d_async,
    output logic [W-1:0]  d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/sect_guard_shift.sv
module sect_guard_shift
    import sect_guard_pkg::*;
#(
    parameter int unsigned NSECT    = 16,
    parameter int unsigned SECT_LSB = 16,
    localparam int unsigned IDX_W   = $clog2(NSECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    output frame_t            frame,
    output logic [IDX_W-1:0]  frame_sect
);
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] BYTES_FULL = CNT_W'(ADDR_BYTES + 1);

    logic             sck_d, cs_d;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_cnt;
    logic [6:0]       part_q;
    logic             op_hit_q;
    logic [IDX_W-1:0] sect_q, sect_n;
    logic [7:0]       byte_n;
    logic             sck_rise, cs_rise;

    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign byte_n   = {part_q, si_s};

    // Pick out the sector index bits that live in the byte now completing
    always_comb begin
        sect_n = sect_q;
        for (int b = 0; b < int'(IDX_W); b++) begin
            if (int'(byte_cnt) >= 1 && int'(byte_cnt) <= int'(ADDR_BYTES) &&
                (int'(SECT_LSB) + b) / 8 == int'(ADDR_BYTES) - int'(byte_cnt))
                sect_n[b] = byte_n[(int'(SECT_LSB) + b) % 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b0;
            cs_d     <= 1'b1;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            part_q   <= '0;
            op_hit_q <= 1'b0;
            sect_q   <= '0;
            frame    <= '0;
        end else begin
            sck_d         <= sck_s;
            cs_d          <= cs_n_s;
            frame.valid   <= cs_rise;
            frame.is_prot <= (byte_cnt != '0) && op_hit_q;
            frame.full    <= (byte_cnt == BYTES_FULL);
            frame.aligned <= (bit_cnt == 3'd0);
            if (cs_n_s) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                part_q   <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                part_q  <= byte_n[6:0];
                if (bit_cnt == 3'd7) begin
                    if (byte_cnt == '0) op_hit_q <= (byte_n == OP_PROTECT);
                    sect_q <= sect_n;
                    if (byte_cnt != BYTES_FULL) byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    assign frame_sect = sect_q;

    // R3: the frame summary is a single-cycle pulse
    assert_frame_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        frame.valid |=> !frame.valid);

    // R6: the bit counter restarts whenever chip-select is high
    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (bit_cnt == 3'd0 && byte_cnt == '0));
endmodule

// File: rtl/sect_guard_regs.sv
module sect_guard_regs
    import sect_guard_pkg::*;
#(
    parameter int unsigned NSECT    = 16,
    localparam int unsigned IDX_W   = $clog2(NSECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frame,
    input  logic [IDX_W-1:0]  frame_sect,
    input  logic              wel_set,
    input  logic              lock_in,
    input  logic [NSECT-1:0]  unprot_mask,
    output logic [NSECT-1:0]  prot_q,
    output logic              wel_q,
    output logic              lock_q
);
    outcome_t outcome;

    assign outcome = classify(frame, wel_q, lock_q);

    for (genvar i = 0; i < int'(NSECT); i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                prot_q[i] <= 1'b1;
            else if (outcome == OUT_COMMIT && frame_sect == IDX_W'(i))
                prot_q[i] <= 1'b1;
            else if (unprot_mask[i])
                prot_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (outcome != OUT_NONE)
                wel_q <= 1'b0;
            else if (wel_set)
                wel_q <= 1'b1;
        end
    end

    // R3: a flag only turns on after a frame has ended
    assert_set_after_frame_R3: assert property (@(posedge clk) disable iff (rst)
        ((prot_q & ~$past(prot_q)) != '0) |-> $past(frame.valid));

    // R3: one frame sets at most one flag
    assert_one_flag_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(prot_q & ~$past(prot_q)) <= 1);

    // R7: with the lock bit set, a protect frame turns no flag on and drops WEL
    assert_lock_ignores_R7: assert property (@(posedge clk) disable iff (rst)
        (frame.valid && frame.is_prot && lock_q) |=>
            ((prot_q & ~$past(prot_q)) == '0) && !wel_q);

    // R9: WEL only falls at the end of a frame
    assert_wel_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(wel_q) |-> $past(frame.valid));
endmodule

// File: rtl/sect_guard.sv
module sect_guard
    import sect_guard_pkg::*;
#(
    parameter int unsigned NSECT    = 16,
    parameter int unsigned SECT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              wel_set,
    input  logic              lock_in,
    input  logic [NSECT-1:0]  unprot_mask,
    output logic [NSECT-1:0]  prot_vec,
    output logic              wel,
    output logic              locked
);
    localparam int unsigned IDX_W = $clog2(NSECT);

    logic [2:0]       pins_s;
    frame_t           frame;
    logic [IDX_W-1:0] frame_sect;

    sect_guard_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({cs_n, sck, si}),
        .d_sync  (pins_s)
    );

    sect_guard_shift #(.NSECT(NSECT), .SECT_LSB(SECT_LSB)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_n_s     (pins_s[2]),
        .sck_s      (pins_s[1]),
        .si_s       (pins_s[0]),
        .frame      (frame),
        .frame_sect (frame_sect)
    );

    sect_guard_regs #(.NSECT(NSECT)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .frame       (frame),
        .frame_sect  (frame_sect),
        .wel_set     (wel_set),
        .lock_in     (lock_in),
        .unprot_mask (unprot_mask),
        .prot_q      (prot_vec),
        .wel_q       (wel),
        .lock_q      (locked)
    );

    assign so    = 1'b0;
    assign so_oe = 1'b0;
endmodule

// File: tb/test_sect_guard.sv
module test_sect_guard;
    localparam int NSECT = 16;

    typedef struct {
        logic [NSECT-1:0] prot;
        logic             wel;
        logic             lock;
        string            req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic wel_set = 1'b0, lock_in = 1'b0;
    logic [NSECT-1:0] unprot_mask = '0;
    logic so, so_oe, wel, locked;
    logic [NSECT-1:0] prot_vec;

    int checks = 0;
    int errors = 0;
    item_t sb_q[$];
    logic [NSECT-1:0] m_prot;
    logic m_wel, m_lock;

    always #5 clk = ~clk;

    sect_guard i_sect_guard (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .wel_set(wel_set), .lock_in(lock_in),
        .unprot_mask(unprot_mask), .prot_vec(prot_vec), .wel(wel), .locked(locked)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expectations and compare against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, "prot_vec", 32'(prot_vec), 32'(it.prot));
                chk(it.req, "wel", 32'(wel), 32'(it.wel));
                chk(it.req, "locked", 32'(locked), 32'(it.lock));
                chk("R10", "so_oe/so", 32'({so_oe, so}), 32'd0);
            end
        end
    end

    task automatic push(input string req);
        item_t it;
        it.prot = m_prot; it.wel = m_wel; it.lock = m_lock; it.req = req;
        sb_q.push_back(it);
        @(negedge clk); @(negedge clk);
    endtask

    // Send nbits bits of data (left-aligned, MSB first) in one CS frame
    task automatic frame(input logic [47:0] data, input int nbits);
        cs_n = 1'b0;
        repeat (4) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = data[47 - i];
            repeat (4) @(posedge clk);
            sck = 1'b1;
            repeat (4) @(posedge clk);
            sck = 1'b0;
        end
        repeat (4) @(posedge clk);
        cs_n = 1'b1;
        repeat (12) @(posedge clk);
    endtask

    task automatic pulse_wel();
        @(posedge clk); wel_set = 1'b1;
        @(posedge clk); wel_set = 1'b0;
        repeat (2) @(posedge clk);
        m_wel = 1'b1;
    endtask

    task automatic pulse_unprot(input logic [NSECT-1:0] m);
        @(posedge clk); unprot_mask = m;
        @(posedge clk); unprot_mask = '0;
        repeat (2) @(posedge clk);
        m_prot = m_prot & ~m;
    endtask

    initial begin
        m_prot = '1; m_wel = 1'b0; m_lock = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        push("R1");                                        // reset state

        pulse_unprot('1);              push("R11");        // clear all flags
        frame({8'h36, 24'h030000, 16'h0}, 32); push("R8"); // WEL low: dropped
        pulse_wel();                   push("R2");
        frame({8'h36, 24'h05ABCD, 16'h0}, 32);             // commit sector 5
        m_prot[5] = 1'b1; m_wel = 1'b0; push("R3");
        pulse_wel();
        frame({8'h36, 24'hF70000, 16'h0}, 32);             // upper bits ignored
        m_prot[7] = 1'b1; m_wel = 1'b0; push("R3");
        pulse_wel();
        frame({8'h36, 24'h0A1234, 8'hFF, 8'h0}, 40);       // trailing byte
        m_prot[10] = 1'b1; m_wel = 1'b0; push("R4");
        pulse_wel();
        frame({8'h36, 16'h0C00, 24'h0}, 24);               // short address
        m_wel = 1'b0; push("R5");
        pulse_wel();
        frame({8'h36, 24'h0B0000, 16'h0}, 35);             // unaligned, partial byte
        m_wel = 1'b0; push("R6");
        pulse_wel();
        frame({8'h36, 24'h0B0000, 8'hA5, 8'h0}, 36);       // full address, then 4 bits
        m_wel = 1'b0; push("R6");
        pulse_wel();
        lock_in = 1'b1; repeat (2) @(posedge clk); m_lock = 1'b1;
        frame({8'h36, 24'h020000, 16'h0}, 32);             // locked
        m_wel = 1'b0; push("R7");
        lock_in = 1'b0; repeat (2) @(posedge clk); m_lock = 1'b0;
        pulse_wel();
        frame({8'h03, 24'h010000, 16'h0}, 32); push("R9"); // other opcode
        frame({8'h36, 40'h0}, 5);              push("R9"); // partial first byte
        frame({8'h36, 24'h0F0000, 16'h0}, 32);             // WEL still usable
        m_prot[15] = 1'b1; m_wel = 1'b0; push("R3");
        pulse_unprot(16'h0020);        push("R11");

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule